// File: doc/BRIEF.md
# Dual-Processor Mailbox Unit

This unit lets two processors, here called side A and side B, pass short messages and interrupts to each other. It holds four mailboxes. Two carry messages from A to B and two carry them from B to A. Each mailbox has a 16-bit data word, a 16-bit command word and a one-bit pending flag. The sender of a mailbox writes it and the receiver reads it. Writing the command word marks the message pending and interrupts the receiver. When the receiver reads the command word back, the flag and the interrupt clear.

Each side has its own simple register port: a word address, a write enable with write data, and a read enable. Read data is registered and appears the cycle after the read enable. Each receiver owns an interrupt enable mask for its incoming mailboxes, so it can silence a mailbox without losing the pending state. Each side sees the same address layout, with k the mailbox index (0 or 1) counted from that side's point of view:

- 2k: outgoing data
- 2k+1: outgoing command
- 4+2k: incoming data
- 5+2k: incoming command
- 8: status
- 9: interrupt mask

Top module: `ipc_mailbox_top`

## Requirements
- R1: The unit holds two mailboxes from A to B and two from B to A. What side A writes at address 2k or 2k+1 reaches side B at address 4+2k or 5+2k, and the same holds with the two sides swapped.
- R2: A read with the read enable set returns the addressed word on the read data output one cycle later. A data word written by the sender is returned unchanged by the receiver's read of incoming data.
- R3: A write to an outgoing command address stores the word and sets that mailbox's flag. From the next cycle the receiver's interrupt bit k is high, if its mask bit k is 1.
- R4: A receiver read of incoming command k (address 5+2k) returns the command word, and clears flag k and interrupt bit k from the next cycle.
- R5: A receiver read of incoming data (address 4+2k) leaves the flag and the interrupt unchanged.
- R6: A write to an outgoing data address alone leaves the flag clear and raises no interrupt.
- R7: Interrupt bit k equals flag k AND mask bit k. The mask sits in bits [1:0] of address 9 and belongs to the receiving side. A masked pending message still shows in status, and it interrupts as soon as the mask bit is set.
- R8: Status at address 8 shows the flags of the side's outgoing mailboxes in bits [1:0] and of its incoming mailboxes in bits [3:2]. This lets a sender poll whether its last message has been consumed.
- R9: If the sender writes a command word in the same cycle that the receiver reads it, the flag stays set and the new word is stored. The read returns the old word.
- R10: After reset, all flags, data words, command words, masks and interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_addr_i | input | 4 | Side A word address |
| a_we_i | input | 1 | Side A write enable |
| a_wdata_i | input | 16 | Side A write data |
| a_re_i | input | 1 | Side A read enable |
| a_rdata_o | output | 16 | Side A read data, valid one cycle after the read |
| irq_a_o | output | 2 | Interrupts to side A, one per incoming mailbox |
| b_addr_i | input | 4 | Side B word address |
| b_we_i | input | 1 | Side B write enable |
| b_wdata_i | input | 16 | Side B write data |
| b_re_i | input | 1 | Side B read enable |
| b_rdata_o | output | 16 | Side B read data, valid one cycle after the read |
| irq_b_o | output | 2 | Interrupts to side B, one per incoming mailbox |

## Verification
A flag in the wrong state shows at the ports one cycle after the access that caused it. It appears as a stuck or missing interrupt bit, and as a wrong bit in either side's status word. A crossed mailbox route or a wrong word register shows as a wrong value on the receiver's read data one cycle after its read enable. The bench therefore checks the interrupts and status straight after each access. It compares every read against a queue of expected words. It covers the same-cycle write and clear collision, where a wrong priority leaves the interrupt low while a message is still unread.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_TX_DATA,
    ACC_TX_CMD,
    ACC_RX_DATA,
    ACC_RX_CMD,
    ACC_STATUS,
    ACC_MASK
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [7:0] idx;
  } acc_t;

  // Outgoing words come first, then incoming words, then status and mask.
  function automatic int unsigned rx_base(input int unsigned nbox);
    return 2 * nbox;
  endfunction

  function automatic int unsigned status_addr(input int unsigned nbox);
    return 4 * nbox;
  endfunction

  function automatic int unsigned mask_addr(input int unsigned nbox);
    return 4 * nbox + 1;
  endfunction

  function automatic acc_t decode_addr(input int unsigned addr, input int unsigned nbox);
    acc_t r;
    r.kind = ACC_NONE;
    r.idx  = '0;
    if (addr < rx_base(nbox)) begin
      r.kind = (addr % 2 == 1) ? ACC_TX_CMD : ACC_TX_DATA;
      r.idx  = 8'(addr / 2);
    end else if (addr < status_addr(nbox)) begin
      r.kind = ((addr - rx_base(nbox)) % 2 == 1) ? ACC_RX_CMD : ACC_RX_DATA;
      r.idx  = 8'((addr - rx_base(nbox)) / 2);
    end else if (addr == status_addr(nbox)) begin
      r.kind = ACC_STATUS;
    end else if (addr == mask_addr(nbox)) begin
      r.kind = ACC_MASK;
    end
    return r;
  endfunction

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_data_i,
  input  logic         wr_cmd_i,
  input  logic [W-1:0] wdata_i,
  input  logic         rd_cmd_i,
  output logic [W-1:0] data_o,
  output logic [W-1:0] cmd_o,
  output logic         flag_o
);

  logic [W-1:0] data_q, cmd_q;
  logic         flag_q;
  logic         flag_next;

  // A new command takes priority over a clearing read in the same cycle.
  always_comb begin
    flag_next = flag_q;
    if (rd_cmd_i) flag_next = 1'b0;
    if (wr_cmd_i) flag_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      cmd_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_data_i) data_q <= wdata_i;
      if (wr_cmd_i)  cmd_q  <= wdata_i;
      flag_q <= flag_next;
    end
  end

  assign data_o = data_q;
  assign cmd_o  = cmd_q;
  assign flag_o = flag_q;

  assert_data_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_i |=> data_o == $past(wdata_i));
  assert_cmd_sets_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd_i |=> flag_o);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cmd_i && !wr_cmd_i) |=> !flag_o);
  assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_cmd_i && !rd_cmd_i) |=> flag_o == $past(flag_o));
  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd_i && rd_cmd_i) |=> (flag_o && cmd_o == $past(wdata_i)));

endmodule

// File: rtl/mbx_port.sv
module mbx_port
  import ipc_mbx_pkg::*;
#(
  parameter int W  = 16,
  parameter int N  = 2,
  parameter int AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [AW-1:0]       addr_i,
  input  logic                we_i,
  input  logic [W-1:0]        wdata_i,
  input  logic                re_i,
  output logic [W-1:0]        rdata_o,
  input  logic [N-1:0][W-1:0] tx_data_i,
  input  logic [N-1:0][W-1:0] tx_cmd_i,
  input  logic [N-1:0]        tx_flag_i,
  input  logic [N-1:0][W-1:0] rx_data_i,
  input  logic [N-1:0][W-1:0] rx_cmd_i,
  input  logic [N-1:0]        rx_flag_i,
  output logic [W-1:0]        wr_value_o,
  output logic [N-1:0]        tx_data_we_o,
  output logic [N-1:0]        tx_cmd_we_o,
  output logic [N-1:0]        rx_cmd_rd_o,
  output logic [N-1:0]        irq_o
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  acc_t         acc;
  logic [N-1:0] mask_q;
  logic [W-1:0] rd_val, rdata_q;
  logic [IW-1:0] sel;

  assign acc = decode_addr(int'(addr_i), N);
  assign sel = acc.idx[IW-1:0];
  assign wr_value_o = wdata_i;

  for (genvar k = 0; k < N; k++) begin : g_strobe
    assign tx_data_we_o[k] = we_i && acc.kind == ACC_TX_DATA && acc.idx == 8'(k);
    assign tx_cmd_we_o[k]  = we_i && acc.kind == ACC_TX_CMD  && acc.idx == 8'(k);
    assign rx_cmd_rd_o[k]  = re_i && acc.kind == ACC_RX_CMD  && acc.idx == 8'(k);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           mask_q <= '0;
    else if (we_i && acc.kind == ACC_MASK) mask_q <= wdata_i[N-1:0];
  end

  always_comb begin
    rd_val = '0;
    unique case (acc.kind)
      ACC_TX_DATA: rd_val = tx_data_i[sel];
      ACC_TX_CMD:  rd_val = tx_cmd_i[sel];
      ACC_RX_DATA: rd_val = rx_data_i[sel];
      ACC_RX_CMD:  rd_val = rx_cmd_i[sel];
      ACC_STATUS:  rd_val[2*N-1:0] = {rx_flag_i, tx_flag_i};
      ACC_MASK:    rd_val[N-1:0] = mask_q;
      default:     rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_q <= '0;
    else if (re_i) rdata_q <= rd_val;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = rx_flag_i & mask_q;

  assert_one_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rx_cmd_rd_o));
  assert_mask_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && int'(addr_i) == mask_addr(N)) |=> irq_o == (rx_flag_i & $past(wdata_i[N-1:0])));

endmodule

// File: rtl/ipc_mailbox_top.sv
module ipc_mailbox_top #(
  parameter int W  = 16,
  parameter int N  = 2,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_addr_i,
  input  logic          a_we_i,
  input  logic [W-1:0]  a_wdata_i,
  input  logic          a_re_i,
  output logic [W-1:0]  a_rdata_o,
  output logic [N-1:0]  irq_a_o,
  input  logic [AW-1:0] b_addr_i,
  input  logic          b_we_i,
  input  logic [W-1:0]  b_wdata_i,
  input  logic          b_re_i,
  output logic [W-1:0]  b_rdata_o,
  output logic [N-1:0]  irq_b_o
);

  // ab_*: sent by A, received by B.  ba_*: sent by B, received by A.
  logic [N-1:0][W-1:0] ab_data, ab_cmd, ba_data, ba_cmd;
  logic [N-1:0]        ab_flag, ba_flag;
  logic [N-1:0]        a_tx_data_we, a_tx_cmd_we, a_rx_cmd_rd;
  logic [N-1:0]        b_tx_data_we, b_tx_cmd_we, b_rx_cmd_rd;
  logic [W-1:0]        a_wr_value, b_wr_value;

  mbx_port #(.W(W), .N(N), .AW(AW)) u_port_a (
    .clk(clk), .rst_n(rst_n),
    .addr_i(a_addr_i), .we_i(a_we_i), .wdata_i(a_wdata_i), .re_i(a_re_i),
    .rdata_o(a_rdata_o),
    .tx_data_i(ab_data), .tx_cmd_i(ab_cmd), .tx_flag_i(ab_flag),
    .rx_data_i(ba_data), .rx_cmd_i(ba_cmd), .rx_flag_i(ba_flag),
    .wr_value_o(a_wr_value),
    .tx_data_we_o(a_tx_data_we), .tx_cmd_we_o(a_tx_cmd_we),
    .rx_cmd_rd_o(a_rx_cmd_rd), .irq_o(irq_a_o)
  );

  mbx_port #(.W(W), .N(N), .AW(AW)) u_port_b (
    .clk(clk), .rst_n(rst_n),
    .addr_i(b_addr_i), .we_i(b_we_i), .wdata_i(b_wdata_i), .re_i(b_re_i),
    .rdata_o(b_rdata_o),
    .tx_data_i(ba_data), .tx_cmd_i(ba_cmd), .tx_flag_i(ba_flag),
    .rx_data_i(ab_data), .rx_cmd_i(ab_cmd), .rx_flag_i(ab_flag),
    .wr_value_o(b_wr_value),
    .tx_data_we_o(b_tx_data_we), .tx_cmd_we_o(b_tx_cmd_we),
    .rx_cmd_rd_o(b_rx_cmd_rd), .irq_o(irq_b_o)
  );

  for (genvar k = 0; k < N; k++) begin : g_box
    mbx_slot #(.W(W)) u_ab (
      .clk(clk), .rst_n(rst_n),
      .wr_data_i(a_tx_data_we[k]), .wr_cmd_i(a_tx_cmd_we[k]), .wdata_i(a_wr_value),
      .rd_cmd_i(b_rx_cmd_rd[k]),
      .data_o(ab_data[k]), .cmd_o(ab_cmd[k]), .flag_o(ab_flag[k])
    );
    mbx_slot #(.W(W)) u_ba (
      .clk(clk), .rst_n(rst_n),
      .wr_data_i(b_tx_data_we[k]), .wr_cmd_i(b_tx_cmd_we[k]), .wdata_i(b_wr_value),
      .rd_cmd_i(a_rx_cmd_rd[k]),
      .data_o(ba_data[k]), .cmd_o(ba_cmd[k]), .flag_o(ba_flag[k])
    );
  end

  assert_irq_a_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_a_o & ~ba_flag) == '0);
  assert_irq_b_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_b_o & ~ab_flag) == '0);
  assert_reset_quiet_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> (ab_flag == '0 && ba_flag == '0));

endmodule

// File: tb/ipc_mailbox_top_tb.sv
module ipc_mailbox_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  a_addr = '0, b_addr = '0;
  logic        a_we = 1'b0, b_we = 1'b0, a_re = 1'b0, b_re = 1'b0;
  logic [15:0] a_wdata = '0, b_wdata = '0;
  logic [15:0] a_rdata, b_rdata;
  logic [1:0]  irq_a, irq_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] qa_val[$], qb_val[$];
  string       qa_tag[$], qb_tag[$];
  logic        pend_a = 1'b0, pend_b = 1'b0;

  always #5 clk = ~clk;

  ipc_mailbox_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_addr_i(a_addr), .a_we_i(a_we), .a_wdata_i(a_wdata), .a_re_i(a_re),
    .a_rdata_o(a_rdata), .irq_a_o(irq_a),
    .b_addr_i(b_addr), .b_we_i(b_we), .b_wdata_i(b_wdata), .b_re_i(b_re),
    .b_rdata_o(b_rdata), .irq_b_o(irq_b)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: a read issued before a rising edge is compared at the next falling edge.
  always @(posedge clk) begin
    pend_a <= a_re;
    pend_b <= b_re;
  end

  always @(negedge clk) begin
    if (pend_a && qa_val.size() > 0) check(qa_tag.pop_front(), a_rdata, qa_val.pop_front());
    if (pend_b && qb_val.size() > 0) check(qb_tag.pop_front(), b_rdata, qb_val.pop_front());
  end

  // Driver: one bus cycle on both sides. Read expectations go into the scoreboard.
  task automatic bus(input logic awe, input logic are, input logic [3:0] aad, input logic [15:0] awd,
                     input logic [15:0] aexp, input string atag,
                     input logic bwe, input logic bre, input logic [3:0] bad, input logic [15:0] bwd,
                     input logic [15:0] bexp, input string btag);
    @(negedge clk);
    a_we = awe; a_re = are; a_addr = aad; a_wdata = awd;
    b_we = bwe; b_re = bre; b_addr = bad; b_wdata = bwd;
    if (are) begin qa_val.push_back(aexp); qa_tag.push_back(atag); end
    if (bre) begin qb_val.push_back(bexp); qb_tag.push_back(btag); end
    @(negedge clk);
    a_we = 1'b0; a_re = 1'b0; b_we = 1'b0; b_re = 1'b0;
  endtask

  task automatic wr_a(input logic [3:0] ad, input logic [15:0] wd);
    bus(1'b1, 1'b0, ad, wd, '0, "", 1'b0, 1'b0, '0, '0, '0, "");
  endtask
  task automatic wr_b(input logic [3:0] ad, input logic [15:0] wd);
    bus(1'b0, 1'b0, '0, '0, '0, "", 1'b1, 1'b0, ad, wd, '0, "");
  endtask
  task automatic rd_a(input logic [3:0] ad, input logic [15:0] exp, input string tag);
    bus(1'b0, 1'b1, ad, '0, exp, tag, 1'b0, 1'b0, '0, '0, '0, "");
  endtask
  task automatic rd_b(input logic [3:0] ad, input logic [15:0] exp, input string tag);
    bus(1'b0, 1'b0, '0, '0, '0, "", 1'b0, 1'b1, ad, '0, exp, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state
    check("R10 irq_a", {14'd0, irq_a}, 16'h0);
    check("R10 irq_b", {14'd0, irq_b}, 16'h0);
    rd_a(4'd8, 16'h0, "R10 status A");
    rd_b(4'd9, 16'h0, "R10 mask B");
    rd_b(4'd4, 16'h0, "R10 data B rx0");
    // Masks: A enables both, B enables only mailbox 0
    wr_a(4'd9, 16'h0003);
    wr_b(4'd9, 16'h0001);
    rd_b(4'd9, 16'h0001, "R7 mask readback");
    // R6: data alone sets no flag
    wr_a(4'd0, 16'h1234);
    check("R6 irq_b after data write", {14'd0, irq_b}, 16'h0);
    rd_a(4'd8, 16'h0, "R6 status A after data write");
    // R3: command raises flag and irq
    wr_a(4'd1, 16'h00A5);
    check("R3 irq_b after cmd", {14'd0, irq_b}, 16'h0001);
    check("R3 irq_a untouched", {14'd0, irq_a}, 16'h0);
    rd_a(4'd8, 16'h0001, "R8 status A tx flag");
    rd_b(4'd8, 16'h0004, "R8 status B rx flag");
    // R5 / R2: data read has no side effect
    rd_b(4'd4, 16'h1234, "R2 data B rx0");
    check("R5 irq_b after data read", {14'd0, irq_b}, 16'h0001);
    // R4: command read clears
    rd_b(4'd5, 16'h00A5, "R4 cmd B rx0");
    check("R4 irq_b after cmd read", {14'd0, irq_b}, 16'h0);
    rd_a(4'd8, 16'h0, "R8 status A consumed");
    // R7: masked mailbox 1
    wr_a(4'd3, 16'h0777);
    check("R7 irq_b masked", {14'd0, irq_b}, 16'h0);
    rd_b(4'd8, 16'h0008, "R7 status B shows masked flag");
    wr_b(4'd9, 16'h0003);
    check("R7 irq_b after unmask", {14'd0, irq_b}, 16'h0002);
    rd_b(4'd7, 16'h0777, "R4 cmd B rx1");
    check("R4 irq_b after rx1 clear", {14'd0, irq_b}, 16'h0);
    // R1: direction B to A
    wr_b(4'd2, 16'hBEEF);
    wr_b(4'd3, 16'h0042);
    check("R1 irq_a from B", {14'd0, irq_a}, 16'h0002);
    check("R1 irq_b unaffected", {14'd0, irq_b}, 16'h0);
    rd_a(4'd6, 16'hBEEF, "R1 data A rx1");
    rd_a(4'd7, 16'h0042, "R1 cmd A rx1");
    check("R4 irq_a after clear", {14'd0, irq_a}, 16'h0);
    rd_b(4'd8, 16'h0, "R8 status B after A consumed");
    // R9: write and clearing read in the same cycle
    wr_a(4'd1, 16'h0011);
    bus(1'b1, 1'b0, 4'd1, 16'h0022, '0, "", 1'b0, 1'b1, 4'd5, '0, 16'h0011, "R9 collision read old");
    check("R9 irq_b stays set", {14'd0, irq_b}, 16'h0001);
    rd_b(4'd5, 16'h0022, "R9 new cmd kept");
    check("R9 irq_b cleared afterwards", {14'd0, irq_b}, 16'h0);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule